// File: doc/BRIEF.md
# Timer Arm, Interrupt and Pulse-Output Control

This block sits beside a 16-bit down-counting timer and decides what the counter and its output pin do on each cycle. A write to the high counter byte arms the timer. An underflow that the counter reports while the timer is armed raises a sticky interrupt flag. Whatever the armed state, the counter bytes are told to reload on every write and on every underflow, and to count down on every other cycle.

A mode bit picks the behaviour after an interrupt. In one-shot mode the armed flag drops on the cycle after the first interrupt-producing underflow. In continuous mode it stays set, so every underflow interrupts. A toggle flip-flop drives the output pin level. A counter write pulls it low, and it flips on each armed underflow. It is held high while the pin-output enable is off. With the pin enabled, one-shot mode gives a single low pulse that runs from the write to the first underflow. Continuous mode gives a square wave.

The counter datapath and the interrupt enable and priority logic live elsewhere. The block only receives the write strobe, the underflow pulse and a flag-clear pulse.

Top module: `tmr_arm_ctl`

## Requirements
- R1: During and after reset the interrupt flag is 0, the pin level is 1 and the timer is not armed.
- R2: Asserting `ctr_wr` arms the timer. A later `underflow` then sets `irq_flag` at the next clock edge.
- R3: An `underflow` while the timer is not armed leaves `irq_flag` unchanged.
- R4: An `underflow` in the same cycle as `ctr_wr` does not set `irq_flag`. The write still arms the timer.
- R5: With `mode_cont`=0, an interrupt-producing underflow disarms the timer from the next cycle on. Later underflows do not set `irq_flag` until another `ctr_wr`.
- R6: With `mode_cont`=1, the timer stays armed, so every underflow sets `irq_flag`.
- R7: `irq_flag` holds until `irq_clr` is pulsed, then reads 0 from the next cycle. When a set and `irq_clr` fall in the same cycle, the flag is 1.
- R8: Every bit of `lane_load` is 1 in a cycle with `ctr_wr` or `underflow`, and every bit of `lane_count` is 1 otherwise. Each lane has exactly one of the two set. Both outputs are combinational from the inputs.
- R9: `ctr_wr` makes `pin_level` 0 at the next edge. This overrides every other pin action, including a disabled pin.
- R10: With `pin_en`=0 and no `ctr_wr`, `pin_level` is 1 at the next edge.
- R11: With `pin_en`=1, an underflow while armed and without `ctr_wr` inverts `pin_level`. Any other cycle holds it.
- R12: After the timer is disarmed, underflows still drive `lane_load` to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctr_wr | input | 1 | Strobe: high counter byte written this cycle |
| underflow | input | 1 | Counter underflow pulse |
| mode_cont | input | 1 | 1 = continuous, 0 = one-shot |
| pin_en | input | 1 | 1 = timer drives the output pin |
| irq_clr | input | 1 | Clears the interrupt flag |
| lane_load | output | LANES | Per counter byte: load from latch this cycle |
| lane_count | output | LANES | Per counter byte: decrement this cycle |
| irq_flag | output | 1 | Sticky timer interrupt flag |
| pin_level | output | 1 | Level for the output pin driver |

## Verification
The armed flag is not visible at the ports. Its state shows only through whether a later underflow sets the flag or flips the pin. The hardest case is the cycle where an underflow, a write and a clear meet on an armed timer, right after a one-shot disarm. The bench reaches it by running every combination of the five inputs back to back from states left by earlier sweeps, in both modes. A bench model tracks the hidden armed state and predicts each output.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
   typedef enum logic [1:0] {
      PIN_HOLD   = 2'd0,
      PIN_TOGGLE = 2'd1,
      PIN_FORCE1 = 2'd2,
      PIN_FORCE0 = 2'd3
   } pin_act_e;

   localparam int unsigned MAX_LANES = 8;
endpackage

// File: rtl/tmr_arm_track.sv
module tmr_arm_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ctr_wr,
   input  logic underflow,
   input  logic mode_cont,
   output logic armed,
   output logic fire
);
   logic armed_q;

   assign fire  = underflow & armed_q & ~ctr_wr;
   assign armed = armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 armed_q <= 1'b0;
      else if (ctr_wr)            armed_q <= 1'b1;
      else if (fire && !mode_cont) armed_q <= 1'b0;
   end
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/tmr_pin_ff.sv
module tmr_pin_ff
   import tmr_ctl_pkg::*;
#(
   parameter bit RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic set_i,
   input  logic tgl_i,
   output logic pin_o
);
   pin_act_e act;

   always_comb begin
      if (clr_i)      act = PIN_FORCE0;
      else if (set_i) act = PIN_FORCE1;
      else if (tgl_i) act = PIN_TOGGLE;
      else            act = PIN_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin_o <= RST_LEVEL;
      else begin
         unique case (act)
            PIN_FORCE0: pin_o <= 1'b0;
            PIN_FORCE1: pin_o <= 1'b1;
            PIN_TOGGLE: pin_o <= ~pin_o;
            default:    pin_o <= pin_o;
         endcase
      end
   end
endmodule

// File: rtl/tmr_cmd_fanout.sv
module tmr_cmd_fanout #(
   parameter int unsigned LANES = 2
) (
   input  logic             reload_i,
   output logic [LANES-1:0] load_o,
   output logic [LANES-1:0] count_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign load_o[g]  = reload_i;
      assign count_o[g] = ~reload_i;
   end
endmodule

// File: rtl/tmr_arm_ctl.sv
module tmr_arm_ctl
   import tmr_ctl_pkg::*;
#(
   parameter int unsigned LANES         = 2,
   parameter bit          PIN_RST_LEVEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctr_wr,
   input  logic             underflow,
   input  logic             mode_cont,
   input  logic             pin_en,
   input  logic             irq_clr,
   output logic [LANES-1:0] lane_load,
   output logic [LANES-1:0] lane_count,
   output logic             irq_flag,
   output logic             pin_level
);
   localparam bit LANES_OK = (LANES >= 1) && (LANES <= MAX_LANES);

   if (!LANES_OK) begin : g_bad_lanes
      $error("tmr_arm_ctl: LANES out of range");
   end

   logic armed;
   logic fire;

   tmr_arm_track u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctr_wr    (ctr_wr),
      .underflow (underflow),
      .mode_cont (mode_cont),
      .armed     (armed),
      .fire      (fire)
   );

   tmr_irq_latch u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fire),
      .clr_i  (irq_clr),
      .flag_o (irq_flag)
   );

   tmr_pin_ff #(.RST_LEVEL(PIN_RST_LEVEL)) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (ctr_wr),
      .set_i (~pin_en),
      .tgl_i (underflow & armed),
      .pin_o (pin_level)
   );

   tmr_cmd_fanout #(.LANES(LANES)) u_cmd (
      .reload_i (ctr_wr | underflow),
      .load_o   (lane_load),
      .count_o  (lane_count)
   );
endmodule

// File: rtl/tmr_arm_ctl_chk.sv
module tmr_arm_ctl_chk #(
   parameter int unsigned LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctr_wr,
   input logic             underflow,
   input logic             pin_en,
   input logic             irq_clr,
   input logic [LANES-1:0] lane_load,
   input logic [LANES-1:0] lane_count,
   input logic             irq_flag,
   input logic             pin_level
);
   assert_lane_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_load ^ lane_count) == {LANES{1'b1}});

   assert_reload_on_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (lane_load == {LANES{1'b1}}));

   assert_wr_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wr |=> !pin_level);

   assert_pin_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_en && !ctr_wr) |=> pin_level);

   assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   assert_irq_rise_needs_uf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_flag && (!underflow || ctr_wr)) |=> !irq_flag);

   assert_pin_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en && !ctr_wr && !underflow) |=> $stable(pin_level));
endmodule

bind tmr_arm_ctl tmr_arm_ctl_chk #(.LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctr_wr     (ctr_wr),
   .underflow  (underflow),
   .pin_en     (pin_en),
   .irq_clr    (irq_clr),
   .lane_load  (lane_load),
   .lane_count (lane_count),
   .irq_flag   (irq_flag),
   .pin_level  (pin_level)
);

// File: tb/tmr_arm_ctl_test.sv
`timescale 1ns/1ps
module tmr_arm_ctl_test;
   localparam int LANES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctr_wr = 1'b0, underflow = 1'b0, mode_cont = 1'b0, pin_en = 1'b0, irq_clr = 1'b0;
   logic [LANES-1:0] lane_load, lane_count;
   logic irq_flag, pin_level;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // model state
   logic m_armed, m_irq, m_pin;

   always #2 clk = ~clk;

   tmr_arm_ctl #(.LANES(LANES)) uut (
      .clk(clk), .rst_n(rst_n), .ctr_wr(ctr_wr), .underflow(underflow),
      .mode_cont(mode_cont), .pin_en(pin_en), .irq_clr(irq_clr),
      .lane_load(lane_load), .lane_count(lane_count),
      .irq_flag(irq_flag), .pin_level(pin_level));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive, check combinational outputs, clock, check registers
   task automatic step(string irq_req, logic wr, logic uf, logic md, logic en, logic clr);
      logic fire, n_irq, n_pin, n_arm;
      string pin_req;
      ctr_wr = wr; underflow = uf; mode_cont = md; pin_en = en; irq_clr = clr;
      #1;
      check("R8 load", 32'(lane_load), (wr | uf) ? 32'(2'b11) : 32'd0);
      check("R8 count", 32'(lane_count), (wr | uf) ? 32'd0 : 32'(2'b11));
      fire  = uf & m_armed & ~wr;
      n_irq = fire ? 1'b1 : (clr ? 1'b0 : m_irq);
      n_pin = wr ? 1'b0 : (!en ? 1'b1 : ((uf & m_armed) ? ~m_pin : m_pin));
      n_arm = wr ? 1'b1 : ((fire & ~md) ? 1'b0 : m_armed);
      pin_req = wr ? "R9 pin" : (!en ? "R10 pin" : "R11 pin");
      @(posedge clk);
      #1;
      m_irq = n_irq; m_pin = n_pin; m_armed = n_arm;
      check(irq_req, 32'(irq_flag), 32'(m_irq));
      check(pin_req, 32'(pin_level), 32'(m_pin));
      ctr_wr = 1'b0; underflow = 1'b0; irq_clr = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(posedge clk);
      #1;
      check("R1 irq in reset", 32'(irq_flag), 32'd0);
      check("R1 pin in reset", 32'(pin_level), 32'd1);
      rst_n = 1'b1;
      m_armed = 1'b0; m_irq = 1'b0; m_pin = 1'b1;

      // R1 / R3: unarmed after reset, underflow gives nothing
      step("R3 unarmed uf", 0, 1, 0, 1, 0);
      check("R1 not armed", 32'(irq_flag), 32'd0);
      // R2: write arms, underflow interrupts; pin low then back high (R11 pulse)
      step("R2 wr", 1, 0, 0, 1, 0);
      check("R9 pulse low", 32'(pin_level), 32'd0);
      step("R2 idle", 0, 0, 0, 1, 0);
      step("R2 armed uf", 0, 1, 0, 1, 0);
      check("R2 irq set", 32'(irq_flag), 32'd1);
      check("R11 pulse end", 32'(pin_level), 32'd1);
      // R7 hold then clear
      step("R7 hold", 0, 0, 0, 1, 0);
      step("R7 clr", 0, 0, 0, 1, 1);
      check("R7 cleared", 32'(irq_flag), 32'd0);
      // R5 disarmed: underflow no irq, no toggle; R12 reload still
      step("R5 disarmed uf", 0, 1, 0, 1, 0);
      check("R5 no irq", 32'(irq_flag), 32'd0);
      check("R5 pin held", 32'(pin_level), 32'd1);
      step("R12 uf reload", 0, 1, 0, 1, 0);
      // R4: write and underflow same cycle
      step("R4 wr+uf", 1, 1, 0, 1, 0);
      check("R4 no irq", 32'(irq_flag), 32'd0);
      step("R4 armed uf", 0, 1, 0, 1, 0);
      check("R4 write armed", 32'(irq_flag), 32'd1);
      // R6 continuous + R7 set beats clear
      step("R6 wr", 1, 0, 1, 1, 1);
      step("R6 uf1", 0, 1, 1, 1, 0);
      step("R7 set+clr", 0, 1, 1, 1, 1);
      check("R7 set wins", 32'(irq_flag), 32'd1);
      step("R6 clr", 0, 0, 1, 1, 1);
      step("R6 uf3", 0, 1, 1, 1, 0);
      check("R6 still armed", 32'(irq_flag), 32'd1);
      // R10 / R9 priority with pin disabled
      step("R10 dis", 0, 1, 1, 0, 0);
      check("R10 forced", 32'(pin_level), 32'd1);
      step("R9 wr dis", 1, 0, 1, 0, 0);
      check("R9 clear over set", 32'(pin_level), 32'd0);

      // near-exhaustive sweep: all 32 input vectors, many orderings
      lfsr = 16'hACE1;
      for (int rep = 0; rep < 200; rep++) begin
         for (int v = 0; v < 32; v++) begin
            logic [4:0] x;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            x = 5'(v) ^ lfsr[4:0];
            step(x[2] ? "R6 sweep irq" : "R5 sweep irq", x[0], x[1], x[2], x[3], x[4]);
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule